// File: doc/BRIEF.md
# Deferred-Commit Setting Register Bank

This block holds the stored settings for a two-channel wiper controller: each channel owns four 6-bit setting registers. A host-side command front end hands it one request per handshake. A request can write a register with host data, copy one channel's present wiper position into one of its registers, or copy both wiper positions into the same-index register of each channel. A request is only held as pending while the chip-select framing input `sel_n` is low. Storage changes only after `sel_n` returns high, and only if the front end reports that the sequence was complete.

At that rising edge a commit starts. The `busy` flag then stays high for `WR_CYCLES` clock cycles, which stands in for a slow non-volatile write. The stored contents change on the cycle that `busy` drops, never earlier. Requests that arrive while `busy` is high are consumed and thrown away. Two read ports serve the stored values. A host port takes one channel and index. A wiper-counter port takes one index per channel and returns every channel's selected register at once.

The command port is valid/ready with `cmd_ready` held high: the block never applies back-pressure. Every beat with `cmd_valid` high is taken on that clock edge. A beat that cannot be used (select high, busy, or reserved opcode) is dropped without effect. `busy` is the status bit a status read returns.

Top module: `setting_bank`

## Requirements
- R1: After reset every stored register reads 0, `busy` is 0 and `cmd_ready` is 1.
- R2: The bank has 2 channels × 4 registers × 6 bits. The host read port returns register `rd_idx` of channel `rd_chan` combinationally. The wiper port returns, in `wc_rd_data[6c+:6]`, register `wc_rd_idx[2c+:2]` of channel c.
- R3: Opcode 2'b00 (write) stores `cmd_data` into register `cmd_idx` of channel `cmd_chan`.
- R4: Opcode 2'b01 (single copy) stores the position of channel `cmd_chan`, taken from `wiper_pos[6c+:6]` at the handshake, into register `cmd_idx` of that channel. Later changes to `wiper_pos` have no effect.
- R5: Opcode 2'b10 (global copy) stores each channel's wiper position, sampled at the handshake, into register `cmd_idx` of that same channel.
- R6: Opcode 2'b11 is reserved. It creates no pending change and no commit.
- R7: A commit starts only on a low-to-high transition of `sel_n` while a change is pending. A beat taken while `sel_n` is high is ignored.
- R8: If `seq_partial` is high in the cycle where `sel_n` rises, the pending change is discarded, `busy` stays low and nothing is stored.
- R9: `busy` rises in the cycle after the `sel_n` rise and stays high for exactly `WR_CYCLES` cycles.
- R10: Stored contents do not change while `busy` is high. The pending change becomes visible in the same cycle that `busy` falls.
- R11: Beats taken while `busy` is high are dropped. They neither change storage nor start a later commit.
- R12: When several beats are taken in one select window, only the last one is committed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sel_n | input | 1 | Chip-select framing, active low; rising edge requests commit |
| seq_partial | input | 1 | High while the front end holds an unfinished sequence |
| cmd_valid | input | 1 | Command beat valid |
| cmd_ready | output | 1 | Command beat accepted (always 1) |
| cmd_op | input | 2 | 00 write, 01 single copy, 10 global copy, 11 reserved |
| cmd_chan | input | 1 | Target channel |
| cmd_idx | input | 2 | Target register index |
| cmd_data | input | 6 | Write data |
| wiper_pos | input | 12 | Present wiper positions, 6 bits per channel |
| busy | output | 1 | Write in progress |
| rd_chan | input | 1 | Host read channel |
| rd_idx | input | 2 | Host read index |
| rd_data | output | 6 | Host read data |
| wc_rd_idx | input | 4 | Wiper-port index, 2 bits per channel |
| wc_rd_data | output | 12 | Wiper-port data, 6 bits per channel |

## Verification
Some properties are checked on every cycle. The length of each busy period is measured. A busy period must start only after a real low-to-high select edge, and never after one flagged as partial. The wiper-side read data may move only on the cycle that busy falls. Other behaviour can only be shown by the bench's scenarios. This covers which value lands in which register for each opcode, wiper sampling at the handshake, last-beat-wins, and beats dropped while busy or with select high.

// File: rtl/sb_pkg.sv
package sb_pkg;
  typedef enum logic [1:0] {
    OP_WRITE    = 2'b00,
    OP_COPY_ONE = 2'b01,
    OP_COPY_ALL = 2'b10,
    OP_RSVD     = 2'b11
  } sb_op_e;
endpackage

// File: rtl/sb_pending.sv
// Holds the one change waiting for the select edge (R12: newest beat overwrites).
module sb_pending
  import sb_pkg::*;
#(
  parameter int NCH  = 2,
  parameter int NREG = 4,
  parameter int DW   = 6,
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int IW  = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  sb_op_e            op,
  input  logic [CHW-1:0]    chan,
  input  logic [IW-1:0]     idx,
  input  logic [DW-1:0]     data,
  input  logic [NCH*DW-1:0] wiper_pos,
  input  logic              clear,
  output logic              pend_valid,
  output logic [IW-1:0]     pend_idx,
  output logic [NCH-1:0]    pend_mask,
  output logic [NCH*DW-1:0] pend_val
);
  logic [NCH-1:0]    nxt_mask;
  logic [NCH*DW-1:0] nxt_val;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    always_comb begin
      nxt_mask[c] = (op == OP_COPY_ALL) || (chan == CHW'(c));
      nxt_val[c*DW +: DW] = (op == OP_WRITE) ? data : wiper_pos[c*DW +: DW];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_valid <= 1'b0;
      pend_idx   <= '0;
      pend_mask  <= '0;
      pend_val   <= '0;
    end else if (take) begin
      pend_valid <= 1'b1;
      pend_idx   <= idx;
      pend_mask  <= nxt_mask;
      pend_val   <= nxt_val;
    end else if (clear) begin
      pend_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/sb_commit_ctrl.sv
// Select-edge detection and the timed write-in-progress window.
module sb_commit_ctrl #(
  parameter int WR_CYCLES = 20,
  localparam int CW = $clog2(WR_CYCLES + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sel_n,
  input  logic seq_partial,
  input  logic pend_valid,
  output logic busy,
  output logic apply,
  output logic drop
);
  logic          sel_q;
  logic          sel_rise;
  logic          start;
  logic [CW-1:0] cnt;

  assign sel_rise = sel_n && !sel_q;
  assign start    = sel_rise && pend_valid && !seq_partial && !busy;
  assign drop     = sel_rise && pend_valid && seq_partial && !busy;
  assign apply    = busy && (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_q <= 1'b1;
      busy  <= 1'b0;
      cnt   <= '0;
    end else begin
      sel_q <= sel_n;
      if (start) begin
        busy <= 1'b1;
        cnt  <= CW'(WR_CYCLES - 1);
      end else if (busy) begin
        if (cnt == '0) busy <= 1'b0;
        else           cnt  <= cnt - 1'b1;
      end
    end
  end
endmodule

// File: rtl/sb_store.sv
// Register array with a host read port and a per-channel wiper read port.
module sb_store #(
  parameter int NCH  = 2,
  parameter int NREG = 4,
  parameter int DW   = 6,
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int IW  = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [IW-1:0]     wr_idx,
  input  logic [NCH-1:0]    wr_mask,
  input  logic [NCH*DW-1:0] wr_val,
  input  logic [CHW-1:0]    rd_chan,
  input  logic [IW-1:0]     rd_idx,
  output logic [DW-1:0]     rd_data,
  input  logic [NCH*IW-1:0] wc_rd_idx,
  output logic [NCH*DW-1:0] wc_rd_data
);
  logic [DW-1:0] mem [NCH][NREG];

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    for (genvar r = 0; r < NREG; r++) begin : g_reg
      always_ff @(posedge clk) begin
        if (!rst_n)
          mem[c][r] <= '0;
        else if (we && wr_mask[c] && (wr_idx == IW'(r)))
          mem[c][r] <= wr_val[c*DW +: DW];
      end
    end
    assign wc_rd_data[c*DW +: DW] = mem[c][wc_rd_idx[c*IW +: IW]];
  end

  assign rd_data = mem[rd_chan][rd_idx];
endmodule

// File: rtl/setting_bank.sv
module setting_bank
  import sb_pkg::*;
#(
  parameter int NCH       = 2,
  parameter int NREG      = 4,
  parameter int DW        = 6,
  parameter int WR_CYCLES = 20,
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int IW  = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_n,
  input  logic              seq_partial,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [1:0]        cmd_op,
  input  logic [CHW-1:0]    cmd_chan,
  input  logic [IW-1:0]     cmd_idx,
  input  logic [DW-1:0]     cmd_data,
  input  logic [NCH*DW-1:0] wiper_pos,
  output logic              busy,
  input  logic [CHW-1:0]    rd_chan,
  input  logic [IW-1:0]     rd_idx,
  output logic [DW-1:0]     rd_data,
  input  logic [NCH*IW-1:0] wc_rd_idx,
  output logic [NCH*DW-1:0] wc_rd_data
);
  sb_op_e            op;
  logic              take;
  logic              apply;
  logic              drop;
  logic              pend_valid;
  logic [IW-1:0]     pend_idx;
  logic [NCH-1:0]    pend_mask;
  logic [NCH*DW-1:0] pend_val;

  assign op        = sb_op_e'(cmd_op);
  assign cmd_ready = 1'b1;
  assign take      = cmd_valid && !sel_n && !busy && (op != OP_RSVD);

  sb_pending #(.NCH(NCH), .NREG(NREG), .DW(DW)) u_pend (
    .clk(clk), .rst_n(rst_n), .take(take), .op(op), .chan(cmd_chan),
    .idx(cmd_idx), .data(cmd_data), .wiper_pos(wiper_pos),
    .clear(apply || drop), .pend_valid(pend_valid), .pend_idx(pend_idx),
    .pend_mask(pend_mask), .pend_val(pend_val)
  );

  sb_commit_ctrl #(.WR_CYCLES(WR_CYCLES)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .seq_partial(seq_partial),
    .pend_valid(pend_valid), .busy(busy), .apply(apply), .drop(drop)
  );

  sb_store #(.NCH(NCH), .NREG(NREG), .DW(DW)) u_store (
    .clk(clk), .rst_n(rst_n), .we(apply), .wr_idx(pend_idx),
    .wr_mask(pend_mask), .wr_val(pend_val), .rd_chan(rd_chan),
    .rd_idx(rd_idx), .rd_data(rd_data), .wc_rd_idx(wc_rd_idx),
    .wc_rd_data(wc_rd_data)
  );
endmodule

// File: rtl/setting_bank_chk.sv
module setting_bank_chk #(
  parameter int NCH       = 2,
  parameter int NREG      = 4,
  parameter int DW        = 6,
  parameter int WR_CYCLES = 20,
  localparam int IW = (NREG > 1) ? $clog2(NREG) : 1,
  localparam int CW = $clog2(WR_CYCLES + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sel_n,
  input logic              seq_partial,
  input logic              busy,
  input logic [NCH*IW-1:0] wc_rd_idx,
  input logic [NCH*DW-1:0] wc_rd_data
);
  logic [CW:0] run;

  always_ff @(posedge clk) begin
    if (!rst_n)    run <= '0;
    else if (busy) run <= run + 1'b1;
    else           run <= '0;
  end

  AST_BUSY_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (run == (CW+1)'(WR_CYCLES))); // R9
  AST_BUSY_MAX: assert property (@(posedge clk) disable iff (!rst_n)
    run <= (CW+1)'(WR_CYCLES)); // R9
  AST_START_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> ($past(sel_n) && !$past(sel_n, 2))); // R7
  AST_NO_START_PARTIAL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !$past(seq_partial)); // R8
  AST_HOLD_UNTIL_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (!$fell(busy) && $stable(wc_rd_idx)) |-> $stable(wc_rd_data)); // R10
endmodule

bind setting_bank setting_bank_chk #(
  .NCH(NCH), .NREG(NREG), .DW(DW), .WR_CYCLES(WR_CYCLES)
) u_chk (
  .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .seq_partial(seq_partial),
  .busy(busy), .wc_rd_idx(wc_rd_idx), .wc_rd_data(wc_rd_data)
);

// File: tb/sim_setting_bank.sv
module sim_setting_bank;
  localparam int CLK_P = 10;
  localparam int WRC   = 20;

  typedef struct packed {
    logic [1:0] op;
    logic       ch;
    logic [1:0] idx;
    logic [5:0] data;
    logic [5:0] w0;
    logic [5:0] w1;
    logic       part;
    logic [5:0] e0;
    logic [5:0] e1;
  } vec_t;

  // op ch idx data w0 w1 part exp_ch0 exp_ch1
  localparam vec_t VECS [9] = '{
    '{2'd0, 1'b0, 2'd1, 6'h2A, 6'h00, 6'h00, 1'b0, 6'h2A, 6'h00}, // R3
    '{2'd0, 1'b1, 2'd1, 6'h15, 6'h00, 6'h00, 1'b0, 6'h2A, 6'h15}, // R3
    '{2'd1, 1'b0, 2'd2, 6'h00, 6'h3F, 6'h11, 1'b0, 6'h3F, 6'h00}, // R4
    '{2'd2, 1'b0, 2'd3, 6'h00, 6'h07, 6'h38, 1'b0, 6'h07, 6'h38}, // R5
    '{2'd0, 1'b1, 2'd3, 6'h01, 6'h00, 6'h00, 1'b1, 6'h07, 6'h38}, // R8
    '{2'd3, 1'b0, 2'd0, 6'h33, 6'h00, 6'h00, 1'b0, 6'h00, 6'h00}, // R6
    '{2'd2, 1'b1, 2'd0, 6'h00, 6'h3F, 6'h00, 1'b0, 6'h3F, 6'h00}, // R5
    '{2'd0, 1'b0, 2'd0, 6'h05, 6'h00, 6'h00, 1'b0, 6'h05, 6'h00}, // R3
    '{2'd1, 1'b1, 2'd1, 6'h00, 6'h12, 6'h2C, 1'b0, 6'h2A, 6'h2C}  // R4
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sel_n = 1'b1;
  logic        seq_partial = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [1:0]  cmd_op = '0;
  logic        cmd_chan = 1'b0;
  logic [1:0]  cmd_idx = '0;
  logic [5:0]  cmd_data = '0;
  logic [11:0] wiper_pos = '0;
  logic        busy;
  logic        rd_chan = 1'b0;
  logic [1:0]  rd_idx = '0;
  logic [5:0]  rd_data;
  logic [3:0]  wc_rd_idx = '0;
  logic [11:0] wc_rd_data;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_P/2) clk = ~clk;

  setting_bank #(.WR_CYCLES(WRC)) u0 (
    .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .seq_partial(seq_partial),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
    .cmd_chan(cmd_chan), .cmd_idx(cmd_idx), .cmd_data(cmd_data),
    .wiper_pos(wiper_pos), .busy(busy), .rd_chan(rd_chan), .rd_idx(rd_idx),
    .rd_data(rd_data), .wc_rd_idx(wc_rd_idx), .wc_rd_data(wc_rd_data)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic rd(input logic ch, input logic [1:0] idx, output int val);
    rd_chan = ch;
    rd_idx  = idx;
    #1;
    val = int'(rd_data);
  endtask

  task automatic send(input logic [1:0] op, input logic ch, input logic [1:0] idx,
                      input logic [5:0] d, input logic [5:0] w0, input logic [5:0] w1);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_chan = ch; cmd_idx = idx;
    cmd_data = d; wiper_pos = {w1, w0};
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic open_sel();
    @(negedge clk);
    sel_n = 1'b0;
  endtask

  task automatic close_sel(input logic part);
    @(negedge clk);
    seq_partial = part;
    sel_n = 1'b1;
    @(negedge clk);
    seq_partial = 1'b0;
  endtask

  task automatic wait_busy(output int n);
    n = 0;
    while (busy && n < 1000) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(CLK_P * 150000);
    n_chk++;
    n_bad++;
    $display("FAIL R9 watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    int v;
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 busy", int'(busy), 0);
    check("R1 ready", int'(cmd_ready), 1);
    rd(1'b1, 2'd3, v);
    check("R1 reg", v, 0);

    // table walk
    for (int i = 0; i < 9; i++) begin
      bit commit;
      commit = !VECS[i].part && (VECS[i].op != 2'd3);
      open_sel();
      send(VECS[i].op, VECS[i].ch, VECS[i].idx, VECS[i].data, VECS[i].w0, VECS[i].w1);
      close_sel(VECS[i].part);
      wait_busy(n);
      check($sformatf("R9 busy length vec%0d", i), n, commit ? WRC : 0);
      rd(1'b0, VECS[i].idx, v);
      check($sformatf("R3 R4 R5 R6 R8 ch0 vec%0d", i), v, int'(VECS[i].e0));
      rd(1'b1, VECS[i].idx, v);
      check($sformatf("R3 R4 R5 R6 R8 ch1 vec%0d", i), v, int'(VECS[i].e1));
    end

    // R10 hold during busy, R11 drop during busy
    open_sel();
    send(2'd0, 1'b0, 2'd1, 6'h10, 6'h00, 6'h00);
    close_sel(1'b0);
    check("R10 busy seen", int'(busy), 1);
    rd(1'b0, 2'd1, v);
    check("R10 old value during busy", v, 'h2A);
    open_sel();
    send(2'd0, 1'b1, 2'd2, 6'h22, 6'h00, 6'h00);
    close_sel(1'b0);
    wait_busy(n);
    rd(1'b0, 2'd1, v);
    check("R10 new value after busy", v, 'h10);
    n = 0;
    repeat (WRC + 5) begin
      @(negedge clk);
      if (busy) n++;
    end
    check("R11 no second commit", n, 0);
    rd(1'b1, 2'd2, v);
    check("R11 dropped write", v, 0);

    // R12 last beat wins
    open_sel();
    send(2'd0, 1'b0, 2'd2, 6'h01, 6'h00, 6'h00);
    send(2'd0, 1'b0, 2'd2, 6'h02, 6'h00, 6'h00);
    close_sel(1'b0);
    wait_busy(n);
    rd(1'b0, 2'd2, v);
    check("R12 last wins", v, 'h02);

    // R7 beat with select high ignored
    send(2'd0, 1'b0, 2'd3, 6'h2F, 6'h00, 6'h00);
    open_sel();
    close_sel(1'b0);
    n = 0;
    repeat (5) begin
      if (busy) n++;
      @(negedge clk);
    end
    check("R7 no commit", n, 0);
    rd(1'b0, 2'd3, v);
    check("R7 reg unchanged", v, 'h07);

    // R4 wiper sampled at handshake
    open_sel();
    send(2'd1, 1'b1, 2'd0, 6'h00, 6'h00, 6'h19);
    wiper_pos = {6'h3C, 6'h3C};
    close_sel(1'b0);
    wait_busy(n);
    rd(1'b1, 2'd0, v);
    check("R4 sampled at handshake", v, 'h19);

    // R2 wiper read port
    wc_rd_idx = {2'd0, 2'd3};
    #1;
    check("R2 wiper port ch0", int'(wc_rd_data[5:0]), 'h07);
    check("R2 wiper port ch1", int'(wc_rd_data[11:6]), 'h19);

    finish_run();
  end
endmodule